// File: doc/BRIEF.md
# 16-bit PC Card Cycle Strobe Controller

This block sits on the host side of a 16-bit PC Card socket and turns one host request into a complete card bus cycle. A request carries an address, write data, a direction bit, a two-bit space code and a byte-width bit. The block latches the request. It then drives the card enables, the region select and exactly one of the four cycle strobes through a fixed sequence: address setup, strobe active, then hold. It reports completion to the host with a one-clock done pulse that carries the read data.

The card can stretch a cycle by holding its wait input low. In I/O space the block samples the card's 16-bit-port indication at the end of address setup. If a 16-bit I/O access meets a port that only takes bytes, the block completes it as two byte accesses, even byte first. A registered card reset output follows a host reset command. While that reset is active, the block accepts no new request.

Top module: `pcc_strobe_ctrl`

## Requirements
- R1: The card enables are active low. A word access drives both low. A byte access at an even address drives only `card_ce_lo_n`, and a byte access at an odd address drives only `card_ce_hi_n`. `card_addr[0]` is 0 for word accesses and equals the host address bit 0 for byte accesses.
- R2: Space codes are 2'b00 common memory, 2'b01 attribute memory, and 2'b10 or 2'b11 I/O. `card_reg_n` stays high for every clock of a common-memory cycle and is low for every clock of an attribute or I/O cycle.
- R3: The strobe follows the request. A memory read drives `card_oe_n` low, a memory write drives `card_we_n` low, an I/O read drives `card_iord_n` low and an I/O write drives `card_iowr_n` low. No more than one strobe is ever low at a time.
- R4: Each access holds the enables and address for SETUP_CLKS clocks with no strobe. The strobe is then low for at least ACTIVE_CLKS clocks. It is followed by HOLD_CLKS clocks with enables still low and no strobe.
- R5: If `card_wait_n` is low in the last clock of the minimum strobe window, or in any later strobe clock, the strobe stays low for one more clock.
- R6: On a 16-bit I/O access, if `card_iois16_n` is high at the end of setup, the access continues as an even byte. A second access with its own setup and hold then follows for the odd byte, with `card_addr[0]`=1 and only `card_ce_hi_n` low. If `card_iois16_n` is low, the access is a single 16-bit access.
- R7: `io16_seen` takes the inverse of `card_iois16_n` at the end of setup of the first access of every I/O request. Memory requests leave it unchanged.
- R8: Read data is captured in the last strobe clock. `card_rdata[7:0]` fills `rdata[7:0]` when the low enable is active, and `card_rdata[15:8]` fills `rdata[15:8]` when the high enable is active. Lanes that are not enabled read as zero, and write requests return zero.
- R9: `busy` is high from the clock after acceptance through the last hold clock. `done` is high for exactly the one clock after that.
- R10: `card_reset` is high during `rst_n` low. Otherwise it follows `card_reset_cmd` one clock later. Requests presented while `card_reset` is high are not accepted.
- R11: A `req_valid` presented while `busy` is high is ignored and does not change the cycle in progress.
- R12: During every clock of a write request, `card_data_oe` is high and `card_wdata` holds the request's write data. During read requests and idle, `card_data_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_reset_cmd | input | 1 | Host command to hold the card in reset |
| req_valid | input | 1 | Request present; accepted when idle and not resetting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | 00 common, 01 attribute, 1x I/O |
| req_byte | input | 1 | 1 = single byte access, 0 = 16-bit access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data, even byte in low lane |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Read data returned with done |
| io16_seen | output | 1 | Last captured 16-bit-port indication |
| card_addr | output | ADDR_W | Card address |
| card_wdata | output | DATA_W | Card write data |
| card_data_oe | output | 1 | Write data drive enable |
| card_rdata | input | DATA_W | Card read data |
| card_ce_lo_n | output | 1 | Even-byte card enable, active low |
| card_ce_hi_n | output | 1 | Odd-byte card enable, active low |
| card_reg_n | output | 1 | Attribute/I/O region select, active low |
| card_oe_n | output | 1 | Memory read strobe |
| card_we_n | output | 1 | Memory write strobe |
| card_iord_n | output | 1 | I/O read strobe |
| card_iowr_n | output | 1 | I/O write strobe |
| card_wait_n | input | 1 | Card wait request, active low |
| card_iois16_n | input | 1 | Card 16-bit port indication, active low |
| card_reset | output | 1 | Card hard reset |

## Verification
The bench targets the split I/O word. A design that sampled the port indication at the wrong clock, or put the odd byte first, would show the wrong enable pattern or the wrong `card_addr[0]` in the second access, and the read would merge the halves the wrong way round. Wait stretching is driven at the exact clock where the minimum window ends, so an off-by-one counter or a design that ignores wait releases the strobe early. A request poked in mid-cycle and a request made during card reset would each start a stray cycle if acceptance were not gated. The 16-bit flag is also checked across a following memory cycle to catch a design that overwrites it.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_t;

   localparam int STB_OE   = 0;
   localparam int STB_WE   = 1;
   localparam int STB_IORD = 2;
   localparam int STB_IOWR = 3;
   localparam int N_STB    = 4;

   function automatic logic [N_STB-1:0] strobe_select(input logic [1:0] space,
                                                       input logic wr);
      logic [N_STB-1:0] s;
      s = '0;
      s[STB_OE]   = !space[1] && !wr;
      s[STB_WE]   = !space[1] &&  wr;
      s[STB_IORD] =  space[1] && !wr;
      s[STB_IOWR] =  space[1] &&  wr;
      return s;
   endfunction

endpackage

// File: rtl/pcc_seq.sv
module pcc_seq
   import pcc_pkg::*;
#(
   parameter int SETUP_CLKS  = 2,
   parameter int ACTIVE_CLKS = 3,
   parameter int HOLD_CLKS   = 1,
   parameter int DATA_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_io,
   input  logic              is_word,
   input  logic              is_read,
   input  logic              lane_lo,
   input  logic              lane_hi,
   input  logic              wait_n,
   input  logic              iois16_n,
   input  logic [DATA_W-1:0] card_rdata,
   output phase_t            phase,
   output logic              split,
   output logic              second,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              io16_flag
);

   localparam int MAX_A = (SETUP_CLKS > ACTIVE_CLKS) ? SETUP_CLKS : ACTIVE_CLKS;
   localparam int MAX_C = (MAX_A > HOLD_CLKS) ? MAX_A : HOLD_CLKS;
   localparam int CW    = (MAX_C < 2) ? 1 : $clog2(MAX_C);
   localparam int HALF  = DATA_W / 2;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         split     <= 1'b0;
         second    <= 1'b0;
         done      <= 1'b0;
         rdata     <= '0;
         io16_flag <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase  <= PH_SETUP;
                  cnt    <= CW'(SETUP_CLKS - 1);
                  split  <= 1'b0;
                  second <= 1'b0;
                  rdata  <= '0;
               end
            end
            PH_SETUP: begin
               if (cnt == '0) begin
                  phase <= PH_ACTIVE;
                  cnt   <= CW'(ACTIVE_CLKS - 1);
                  if (is_io && !second) begin
                     io16_flag <= !iois16_n;
                     split     <= is_word && iois16_n;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_ACTIVE: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else if (wait_n) begin
                  phase <= PH_HOLD;
                  cnt   <= CW'(HOLD_CLKS - 1);
                  if (is_read && lane_lo) rdata[HALF-1:0]      <= card_rdata[HALF-1:0];
                  if (is_read && lane_hi) rdata[DATA_W-1:HALF] <= card_rdata[DATA_W-1:HALF];
               end
            end
            PH_HOLD: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else if (split && !second) begin
                  phase  <= PH_SETUP;
                  cnt    <= CW'(SETUP_CLKS - 1);
                  second <= 1'b1;
               end else begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pcc_lane_steer.sv
module pcc_lane_steer
   import pcc_pkg::*;
(
   input  phase_t phase,
   input  logic   addr0,
   input  logic   is_word,
   input  logic   split,
   input  logic   second,
   output logic   lane_lo,
   output logic   lane_hi,
   output logic   ce_lo_n,
   output logic   ce_hi_n,
   output logic   card_a0
);

   logic engaged;

   always_comb begin
      engaged = (phase != PH_IDLE);
      if (is_word) begin
         lane_lo = split ? !second : 1'b1;
         lane_hi = split ?  second : 1'b1;
         card_a0 = split &&  second;
      end else begin
         lane_lo = !addr0;
         lane_hi =  addr0;
         card_a0 =  addr0;
      end
      ce_lo_n = !(engaged && lane_lo);
      ce_hi_n = !(engaged && lane_hi);
   end

endmodule

// File: rtl/pcc_strobe_dec.sv
module pcc_strobe_dec
   import pcc_pkg::*;
(
   input  phase_t            phase,
   input  logic [1:0]        space,
   input  logic              is_write,
   output logic [N_STB-1:0]  strobe_n,
   output logic              reg_n
);

   logic [N_STB-1:0] sel;
   logic             run;

   assign sel   = strobe_select(space, is_write);
   assign run   = (phase == PH_ACTIVE);
   assign reg_n = !((phase != PH_IDLE) && (space != 2'b00));

   for (genvar i = 0; i < N_STB; i++) begin : g_stb
      assign strobe_n[i] = !(run && sel[i]);
   end

endmodule

// File: rtl/pcc_strobe_ctrl.sv
module pcc_strobe_ctrl
   import pcc_pkg::*;
#(
   parameter int ADDR_W      = 26,
   parameter int DATA_W      = 16,
   parameter int SETUP_CLKS  = 2,
   parameter int ACTIVE_CLKS = 3,
   parameter int HOLD_CLKS   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              card_reset_cmd,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_space,
   input  logic              req_byte,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              io16_seen,
   output logic [ADDR_W-1:0] card_addr,
   output logic [DATA_W-1:0] card_wdata,
   output logic              card_data_oe,
   input  logic [DATA_W-1:0] card_rdata,
   output logic              card_ce_lo_n,
   output logic              card_ce_hi_n,
   output logic              card_reg_n,
   output logic              card_oe_n,
   output logic              card_we_n,
   output logic              card_iord_n,
   output logic              card_iowr_n,
   input  logic              card_wait_n,
   input  logic              card_iois16_n,
   output logic              card_reset
);

   if (DATA_W != 16) begin : g_bad_width
      $error("pcc_strobe_ctrl: DATA_W must be 16");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("pcc_strobe_ctrl: ADDR_W must be at least 2");
   end
   if (SETUP_CLKS < 1 || ACTIVE_CLKS < 1 || HOLD_CLKS < 1) begin : g_bad_count
      $error("pcc_strobe_ctrl: phase counts must be at least 1");
   end

   phase_t            phase;
   logic              split, second, start;
   logic              lat_write, lat_byte;
   logic [1:0]        lat_space;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_wdata;
   logic              lane_lo, lane_hi, a0;
   logic [N_STB-1:0]  strobe_n;

   assign start = req_valid && (phase == PH_IDLE) && !card_reset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_write  <= 1'b0;
         lat_byte   <= 1'b0;
         lat_space  <= 2'b00;
         lat_addr   <= '0;
         lat_wdata  <= '0;
         card_reset <= 1'b1;
      end else begin
         card_reset <= card_reset_cmd;
         if (start) begin
            lat_write <= req_write;
            lat_byte  <= req_byte;
            lat_space <= req_space;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
         end
      end
   end

   pcc_seq #(
      .SETUP_CLKS (SETUP_CLKS),
      .ACTIVE_CLKS(ACTIVE_CLKS),
      .HOLD_CLKS  (HOLD_CLKS),
      .DATA_W     (DATA_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .is_io     (lat_space[1]),
      .is_word   (!lat_byte),
      .is_read   (!lat_write),
      .lane_lo   (lane_lo),
      .lane_hi   (lane_hi),
      .wait_n    (card_wait_n),
      .iois16_n  (card_iois16_n),
      .card_rdata(card_rdata),
      .phase     (phase),
      .split     (split),
      .second    (second),
      .done      (done),
      .rdata     (rdata),
      .io16_flag (io16_seen)
   );

   pcc_lane_steer u_steer (
      .phase  (phase),
      .addr0  (lat_addr[0]),
      .is_word(!lat_byte),
      .split  (split),
      .second (second),
      .lane_lo(lane_lo),
      .lane_hi(lane_hi),
      .ce_lo_n(card_ce_lo_n),
      .ce_hi_n(card_ce_hi_n),
      .card_a0(a0)
   );

   pcc_strobe_dec u_dec (
      .phase   (phase),
      .space   (lat_space),
      .is_write(lat_write),
      .strobe_n(strobe_n),
      .reg_n   (card_reg_n)
   );

   assign busy         = (phase != PH_IDLE);
   assign card_addr    = {lat_addr[ADDR_W-1:1], a0};
   assign card_wdata   = lat_wdata;
   assign card_data_oe = busy && lat_write;
   assign card_oe_n    = strobe_n[STB_OE];
   assign card_we_n    = strobe_n[STB_WE];
   assign card_iord_n  = strobe_n[STB_IORD];
   assign card_iowr_n  = strobe_n[STB_IOWR];

endmodule

// File: rtl/pcc_strobe_chk.sv
module pcc_strobe_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic card_reset,
   input logic card_ce_lo_n,
   input logic card_ce_hi_n,
   input logic card_reg_n,
   input logic card_oe_n,
   input logic card_we_n,
   input logic card_iord_n,
   input logic card_iowr_n,
   input logic card_wait_n
);

   logic stb_any, ce_any;
   assign stb_any = !card_oe_n || !card_we_n || !card_iord_n || !card_iowr_n;
   assign ce_any  = !card_ce_lo_n || !card_ce_hi_n;

   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({!card_oe_n, !card_we_n, !card_iord_n, !card_iowr_n}) <= 1);

   assert_strobe_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stb_any |-> ce_any);

   assert_setup_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stb_any) |-> $past(ce_any));

   assert_wait_extends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_any && !card_wait_n) |=> stb_any);

   assert_io_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!card_iord_n || !card_iowr_n) |-> !card_reg_n);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_reset_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (card_reset && !busy) |=> !busy);

endmodule

bind pcc_strobe_ctrl pcc_strobe_chk u_pcc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .card_reset  (card_reset),
   .card_ce_lo_n(card_ce_lo_n),
   .card_ce_hi_n(card_ce_hi_n),
   .card_reg_n  (card_reg_n),
   .card_oe_n   (card_oe_n),
   .card_we_n   (card_we_n),
   .card_iord_n (card_iord_n),
   .card_iowr_n (card_iowr_n),
   .card_wait_n (card_wait_n)
);

// File: tb/pcc_strobe_ctrl_bench.sv
module pcc_strobe_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 26;
   localparam int S  = 2;
   localparam int A  = 3;
   localparam int H  = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          card_reset_cmd = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [1:0]    req_space = 2'b00;
   logic          req_byte = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [15:0]   req_wdata = '0;
   logic          busy, done, io16_seen, card_data_oe;
   logic [15:0]   rdata, card_wdata;
   logic [AW-1:0] card_addr;
   logic [15:0]   card_rdata = '0;
   logic          card_ce_lo_n, card_ce_hi_n, card_reg_n;
   logic          card_oe_n, card_we_n, card_iord_n, card_iowr_n;
   logic          card_wait_n = 1'b1;
   logic          card_iois16_n = 1'b1;
   logic          card_reset;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pcc_strobe_ctrl #(
      .ADDR_W(AW), .DATA_W(16), .SETUP_CLKS(S), .ACTIVE_CLKS(A), .HOLD_CLKS(H)
   ) u_pcc_strobe_ctrl (
      .clk(clk), .rst_n(rst_n), .card_reset_cmd(card_reset_cmd),
      .req_valid(req_valid), .req_write(req_write), .req_space(req_space),
      .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rdata(rdata), .io16_seen(io16_seen),
      .card_addr(card_addr), .card_wdata(card_wdata), .card_data_oe(card_data_oe),
      .card_rdata(card_rdata), .card_ce_lo_n(card_ce_lo_n), .card_ce_hi_n(card_ce_hi_n),
      .card_reg_n(card_reg_n), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
      .card_iord_n(card_iord_n), .card_iowr_n(card_iowr_n),
      .card_wait_n(card_wait_n), .card_iois16_n(card_iois16_n), .card_reset(card_reset)
   );

   // Expected state of one clock, plus the card-side stimulus for that clock.
   typedef struct packed {
      logic [1:0]  ce;     // {lo_n, hi_n}
      logic        rg;
      logic [3:0]  stb;    // {oe_n, we_n, iord_n, iowr_n}
      logic        a0;
      logic        chk_a0;
      logic        bsy;
      logic        dn;
      logic        doe;
      logic        wt;
      logic        i16;
      logic [15:0] rdv;
   } ent_t;

   ent_t        q[$];
   int          n_chk = 0;
   int          n_fail = 0;
   int          cyc = 0;
   logic [15:0] exp_rdata = '0;
   logic [15:0] exp_wdata = '0;
   logic        exp_io16 = 1'b0;
   logic        exp_crst = 1'b1;
   string       cur_tag = "reset";

   function automatic ent_t idle_ent();
      ent_t e;
      e = '0;
      e.ce = 2'b11; e.rg = 1'b1; e.stb = 4'hf;
      e.wt = 1'b1;  e.i16 = 1'b1;
      return e;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s (%s): actual %h expected %h at cycle %0d", tag, cur_tag, act, exp, cyc);
      end
   endtask

   task automatic tick();
      ent_t e;
      @(negedge clk);
      e = (q.size() > 0) ? q.pop_front() : idle_ent();
      chk("R1 enables", {30'd0, card_ce_lo_n, card_ce_hi_n}, {30'd0, e.ce});
      chk("R2 region", {31'd0, card_reg_n}, {31'd0, e.rg});
      chk("R3 strobes", {28'd0, card_oe_n, card_we_n, card_iord_n, card_iowr_n}, {28'd0, e.stb});
      if (e.chk_a0) chk("R1 addr0", {31'd0, card_addr[0]}, {31'd0, e.a0});
      chk("R9 busy", {31'd0, busy}, {31'd0, e.bsy});
      chk("R9 done", {31'd0, done}, {31'd0, e.dn});
      chk("R12 data_oe", {31'd0, card_data_oe}, {31'd0, e.doe});
      chk("R10 card_reset", {31'd0, card_reset}, {31'd0, exp_crst});
      if (e.doe) chk("R12 wdata", {16'd0, card_wdata}, {16'd0, exp_wdata});
      if (e.dn) begin
         chk("R8 rdata", {16'd0, rdata}, {16'd0, exp_rdata});
         chk("R7 io16_seen", {31'd0, io16_seen}, {31'd0, exp_io16});
      end
      card_wait_n   = e.wt;
      card_iois16_n = e.i16;
      card_rdata    = e.rdv;
   endtask

   task automatic push_access(input logic [1:0] ce_set, input logic [1:0] ce_run,
                              input logic a0, input logic [1:0] sp, input logic wr,
                              input logic i16drv, input int nw, input logic [15:0] rdv);
      ent_t e;
      logic [3:0] stb;
      stb = {!(!sp[1] && !wr), !(!sp[1] && wr), !(sp[1] && !wr), !(sp[1] && wr)};
      e = idle_ent();
      e.rg = (sp == 2'b00); e.a0 = a0; e.chk_a0 = 1'b1; e.bsy = 1'b1; e.doe = wr;
      for (int k = 0; k < S; k++) begin
         e.ce = ce_set; e.stb = 4'hf; e.wt = 1'b1; e.i16 = i16drv; e.rdv = '0;
         q.push_back(e);
      end
      for (int k = 0; k < A + nw; k++) begin
         e.ce = ce_run; e.stb = stb; e.i16 = 1'b1; e.rdv = rdv;
         e.wt = !((k >= A - 1) && (k < A - 1 + nw));
         q.push_back(e);
      end
      for (int k = 0; k < H; k++) begin
         e.ce = ce_run; e.stb = 4'hf; e.wt = 1'b1; e.rdv = '0;
         q.push_back(e);
      end
   endtask

   task automatic do_txn(input string tag, input logic wr, input logic [1:0] sp,
                         input logic byt, input logic [AW-1:0] addr, input logic [15:0] wd,
                         input logic [15:0] rd_a, input logic [15:0] rd_b,
                         input logic capable, input int nw, input logic poke);
      ent_t d;
      int n;
      cur_tag   = tag;
      exp_wdata = wd;
      if (byt) begin
         push_access(addr[0] ? 2'b10 : 2'b01, addr[0] ? 2'b10 : 2'b01, addr[0], sp, wr,
                     sp[1] ? !capable : 1'b1, nw, rd_a);
         exp_rdata = addr[0] ? {rd_a[15:8], 8'h00} : {8'h00, rd_a[7:0]};
      end else if (sp[1] && !capable) begin
         push_access(2'b00, 2'b01, 1'b0, sp, wr, 1'b1, nw, rd_a);
         push_access(2'b10, 2'b10, 1'b1, sp, wr, 1'b1, nw, rd_b);
         exp_rdata = {rd_b[15:8], rd_a[7:0]};
      end else begin
         push_access(2'b00, 2'b00, 1'b0, sp, wr, sp[1] ? !capable : 1'b1, nw, rd_a);
         exp_rdata = rd_a;
      end
      if (wr) exp_rdata = '0;
      if (sp[1]) exp_io16 = capable;
      d = idle_ent(); d.dn = 1'b1;
      q.push_back(d);
      req_write = wr; req_space = sp; req_byte = byt; req_addr = addr; req_wdata = wd;
      req_valid = 1'b1;
      tick();
      req_valid = 1'b0;
      n = 1;
      while (q.size() > 0) begin
         if (poke && n == 2) begin
            req_write = !wr; req_space = 2'b01; req_byte = 1'b1; req_addr = ~addr;
            req_valid = 1'b1;
         end
         tick();
         if (poke && n == 2) req_valid = 1'b0;
         n++;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         n_fail++;
         $display("FAIL watchdog R9: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // reset state: card held in reset, bus idle (R10, R9)
      repeat (3) tick();
      rst_n = 1'b1;
      exp_crst = card_reset_cmd;
      tick();
      tick();

      do_txn("R4 R8 common word read", 1'b0, 2'b00, 1'b0, 26'h0001234, 16'h0, 16'hA55A, 16'h0, 1'b0, 0, 1'b0);
      do_txn("R2 R8 attr even byte read", 1'b0, 2'b01, 1'b1, 26'h0000100, 16'h0, 16'h3C7E, 16'h0, 1'b0, 0, 1'b0);
      do_txn("R1 R12 common odd byte write", 1'b1, 2'b00, 1'b1, 26'h0000201, 16'hBE00, 16'h0, 16'h0, 1'b0, 0, 1'b0);
      do_txn("R5 wait stretch word read", 1'b0, 2'b00, 1'b0, 26'h0000040, 16'h0, 16'h1357, 16'h0, 1'b0, 4, 1'b0);
      do_txn("R6 R7 io word read 16-bit port", 1'b0, 2'b10, 1'b0, 26'h00003F8, 16'h0, 16'hC0DE, 16'h0, 1'b1, 0, 1'b0);
      do_txn("R6 R8 io word read split", 1'b0, 2'b10, 1'b0, 26'h00002F8, 16'h0, 16'h11AB, 16'hCD22, 1'b0, 1, 1'b0);
      do_txn("R6 R12 io word write split", 1'b1, 2'b11, 1'b0, 26'h0000300, 16'h9876, 16'h0, 16'h0, 1'b0, 0, 1'b0);
      do_txn("R7 io odd byte read 16-bit port", 1'b0, 2'b10, 1'b1, 26'h0000301, 16'h0, 16'h5A00, 16'h0, 1'b1, 2, 1'b0);
      do_txn("R7 memory keeps io16 flag", 1'b1, 2'b01, 1'b0, 26'h0000008, 16'h4242, 16'h0, 16'h0, 1'b0, 0, 1'b0);
      do_txn("R11 request ignored while busy", 1'b0, 2'b00, 1'b1, 26'h0000010, 16'h0, 16'h00EE, 16'h0, 1'b0, 1, 1'b1);

      // R10: card reset follows command, requests refused meanwhile
      cur_tag = "R10 card reset";
      card_reset_cmd = 1'b1; exp_crst = 1'b1;
      tick();
      req_valid = 1'b1; req_space = 2'b00; req_byte = 1'b0; req_write = 1'b0;
      tick();
      tick();
      req_valid = 1'b0;
      card_reset_cmd = 1'b0; exp_crst = 1'b0;
      tick();
      tick();

      do_txn("R3 back to back io write after reset", 1'b1, 2'b10, 1'b1, 26'h0000080, 16'h0077, 16'h0, 16'h0, 1'b0, 0, 1'b0);
      do_txn("R3 R2 attr word read", 1'b0, 2'b01, 1'b0, 26'h0000082, 16'h0, 16'hF00F, 16'h0, 1'b0, 0, 1'b0);
      tick();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule